// File: doc/BRIEF.md
# Stallable Quadword Receive Buffer

This block is the receiving end of a DMA stream. A sender presents 128-bit quadword beats on a valid/ready handshake, each beat tagged with an end-of-transfer flag. Every beat the block accepts is stored in the next free slot of a small indexed buffer, starting from slot 0. The block also keeps a 32-bit count of accepted beats and a sticky flag that records that an end-marked beat has arrived.

A `hold` input lets the surrounding logic pause the stream at any point in a transfer, including partway through it. While `hold` is high the block withholds ready, so the slot order and the counts stay exact across the pause. A separate indexed read port lets a host fetch any stored slot one clock after asking. For every beat that lands in a slot, the block gives a one-cycle receive event that carries the slot index and the low half of the data.

Top module: `qw_rx_buffer`

## Requirements
- R1: `in_ready` equals the inverse of `hold` in the same cycle, with no register on that path.
- R2: On a clock edge where `hold` is high, no beat is accepted. `beat_count`, the slot pointer and the event output do not advance, even when `in_valid` is high.
- R3: A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. The first stored beat goes to slot 0, the next to slot 1, and so on in arrival order, with no beat repeated or skipped across a hold.
- R4: `beat_count` is 32 bits wide and rises by exactly one after each accepting edge. Its new value can be seen from that edge on.
- R5: `last_flag` goes to 1 after an edge that accepts a beat with `in_last` high, and stays at 1 until reset.
- R6: When `rd_en` is high on an edge, `rd_valid` is 1 and `rd_data` holds the slot at `rd_idx` during the next cycle. `rd_valid` is 0 after any edge where `rd_en` is low. If the same slot is written on that edge, the read returns the slot's previous contents.
- R7: Once DEPTH beats have been stored (DEPTH defaults to 8), any further accepted beat is still counted and still updates `last_flag`. It is not stored, it raises no event, and no slot changes. No error is flagged.
- R8: After each edge that stores a beat, `evt_valid` is 1 for exactly one cycle. During that cycle `evt_slot` gives the slot written and `evt_payload` gives bits 63:0 of the stored data.
- R9: When `rst_n` is low on an edge (synchronous reset), the block clears `beat_count`, `last_flag`, `rd_valid`, `evt_valid` and the slot pointer, so the next stored beat goes to slot 0. Slot contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sender has a beat on `in_data` |
| in_data | input | 128 | Quadword beat data |
| in_last | input | 1 | Beat is the final one of a transfer |
| in_ready | output | 1 | Block can accept a beat this cycle |
| hold | input | 1 | Pause request; forces `in_ready` low |
| rd_en | input | 1 | Host read request |
| rd_idx | input | $clog2(DEPTH) | Slot to read |
| rd_data | output | 128 | Read result, valid when `rd_valid` |
| rd_valid | output | 1 | Read result present, one cycle after `rd_en` |
| beat_count | output | 32 | Number of beats accepted since reset |
| last_flag | output | 1 | Sticky: an end-marked beat was accepted |
| evt_valid | output | 1 | One-cycle receive event for a stored beat |
| evt_slot | output | $clog2(DEPTH) | Slot written by the reported beat |
| evt_payload | output | 64 | Bits 63:0 of the reported beat |

## Verification
`in_ready` is combinational, so the bench checks it half a nanosecond after driving `hold`, before the next edge. The count, sticky flag, receive event and read result all come from registers. A stimulus applied before edge E therefore shows up on these outputs after E. The bench drives each cycle's inputs just after a falling edge, updates its model for edge E, and checks all four outputs 1 ns after E. The read model is sampled before it takes that cycle's store, so a read and a write to the same slot on one edge are checked against the slot's old contents.

// File: rtl/qwrx_pkg.sv
// Shared widths and types for the quadword receive buffer.
// Assumes 128-bit beats and a 64-bit event payload taken from the low half.
package qwrx_pkg;
    localparam int QW_W  = 128;
    localparam int EVT_W = 64;
    localparam int CNT_W = 32;

    typedef logic [QW_W-1:0]  qword_t;
    typedef logic [EVT_W-1:0] evt_word_t;

    // Extract the part of a beat that the receive event carries.
    function automatic evt_word_t evt_part(input qword_t beat);
        return beat[EVT_W-1:0];
    endfunction
endpackage

// File: rtl/qwrx_ctrl.sv
// Handshake and bookkeeping for the receive buffer.
// Derives ready from the hold input, decides acceptance and storage,
// and owns the slot pointer, the beat counter and the sticky end flag.
// Assumes DEPTH is a power of two of at least 2.
module qwrx_ctrl #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_last,
    input  logic                      hold,
    output logic                      in_ready,
    output logic                      wr_fire,
    output logic [IDX_W-1:0]          wr_slot,
    output logic [qwrx_pkg::CNT_W-1:0] beat_count,
    output logic                      last_flag
);
    localparam int PTR_W = IDX_W + 1;
    localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(DEPTH);

    logic [PTR_W-1:0] wptr;
    logic             full;
    logic             accept;

    // Ready, acceptance and store decisions for the current cycle.
    always_comb begin
        in_ready = !hold;
        full     = (wptr == PTR_FULL);
        accept   = in_valid && in_ready;
        wr_fire  = accept && !full;
        wr_slot  = wptr[IDX_W-1:0];
    end

    // Pointer, counter and sticky flag update on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr       <= '0;
            beat_count <= '0;
            last_flag  <= 1'b0;
        end else if (accept) begin
            beat_count <= beat_count + qwrx_pkg::CNT_W'(1);
            if (!full) wptr <= wptr + PTR_W'(1);
            if (in_last) last_flag <= 1'b1;
        end
    end

    // R7
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wptr <= PTR_FULL);

    // R2
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(wptr) && $stable(beat_count)));

    // R7
    full_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr == PTR_FULL) |=> (wptr == PTR_FULL));
endmodule

// File: rtl/qwrx_store.sv
// Slot storage with one write port and a registered indexed read port.
// Each slot is a plain register without reset; a read that hits the
// slot written on the same edge returns the older contents.
module qwrx_store #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_slot,
    input  qwrx_pkg::qword_t       wr_data,
    input  logic                   rd_en,
    input  logic [IDX_W-1:0]       rd_idx,
    output qwrx_pkg::qword_t       rd_data,
    output logic                   rd_valid
);
    qwrx_pkg::qword_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture a beat into this slot when it is the write target.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == IDX_W'(g))) slot_q[g] <= wr_data;
        end
    end

    // Registered read data, loaded only on a request.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= slot_q[rd_idx];
    end

    // Read-valid strobe, one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_en;
    end

    // R6
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R6
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

// File: rtl/qwrx_event.sv
// Receive-event generator: turns each store into a one-cycle registered
// pulse carrying the slot index and the low half of the stored beat.
module qwrx_event #(
    parameter int IDX_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic [IDX_W-1:0]        slot,
    input  qwrx_pkg::qword_t        beat,
    output logic                    evt_valid,
    output logic [IDX_W-1:0]        evt_slot,
    output qwrx_pkg::evt_word_t     evt_payload
);
    // Pulse for one cycle after each store.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_valid <= 1'b0;
        else        evt_valid <= fire;
    end

    // Latch the event fields with the store so they match the pulse.
    always_ff @(posedge clk) begin
        if (fire) begin
            evt_slot    <= slot;
            evt_payload <= qwrx_pkg::evt_part(beat);
        end
    end

    // R8
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !$past(fire)) |-> 1'b0);
endmodule

// File: rtl/qw_rx_buffer.sv
// Stallable quadword receive buffer, top level.
// Accepts 128-bit beats on valid/ready, stores them in order in DEPTH
// slots, counts beats, records an end-marked beat, serves indexed reads
// and reports each stored beat as a one-cycle event. Hold may be raised
// at any cycle; beats arriving once the buffer is full are counted only.
// Assumes DEPTH is a power of two of at least 2.
module qw_rx_buffer #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [127:0]     in_data,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             hold,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [127:0]     rd_data,
    output logic             rd_valid,
    output logic [31:0]      beat_count,
    output logic             last_flag,
    output logic             evt_valid,
    output logic [IDX_W-1:0] evt_slot,
    output logic [63:0]      evt_payload
);
    logic             wr_fire;
    logic [IDX_W-1:0] wr_slot;

    qwrx_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .hold       (hold),
        .in_ready   (in_ready),
        .wr_fire    (wr_fire),
        .wr_slot    (wr_slot),
        .beat_count (beat_count),
        .last_flag  (last_flag)
    );

    qwrx_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_fire),
        .wr_slot  (wr_slot),
        .wr_data  (in_data),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    qwrx_event #(.IDX_W(IDX_W)) u_event (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (wr_fire),
        .slot        (wr_slot),
        .beat        (in_data),
        .evt_valid   (evt_valid),
        .evt_slot    (evt_slot),
        .evt_payload (evt_payload)
    );

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (beat_count == $past(beat_count) + 32'd1));

    // R2
    hold_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !evt_valid);

    // R5
    last_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_flag |=> last_flag);

    // R5
    last_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> last_flag);

    // R8
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(in_valid && in_ready));

    // R8
    evt_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_payload == $past(in_data[63:0])));
endmodule

// File: tb/qw_rx_buffer_tb.sv
`timescale 1ns/1ps
module qw_rx_buffer_tb;
    localparam int DEPTH = 8;
    localparam int IDX_W = $clog2(DEPTH);

    logic             clk;
    logic             rst_n;
    logic             in_valid;
    logic [127:0]     in_data;
    logic             in_last;
    logic             in_ready;
    logic             hold;
    logic             rd_en;
    logic [IDX_W-1:0] rd_idx;
    logic [127:0]     rd_data;
    logic             rd_valid;
    logic [31:0]      beat_count;
    logic             last_flag;
    logic             evt_valid;
    logic [IDX_W-1:0] evt_slot;
    logic [63:0]      evt_payload;

    qw_rx_buffer #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .hold(hold),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .beat_count(beat_count), .last_flag(last_flag),
        .evt_valid(evt_valid), .evt_slot(evt_slot), .evt_payload(evt_payload)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int unsigned total;
    int unsigned bad;

    // Reference model state.
    logic [127:0] m_mem [DEPTH];
    bit           m_wr  [DEPTH];
    int unsigned  m_count;
    bit           m_last;
    int           m_ptr;

    function automatic logic exp_ready(input logic h);
        return !h;
    endfunction

    function automatic logic [127:0] low_half(input logic [127:0] d);
        return {64'd0, d[63:0]};
    endfunction

    function automatic logic [127:0] pattern(input int i);
        return {4{32'hC0DE_0000 + 32'(i) * 32'h0101}};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: drive at current time, check ready, step the model, check outputs after the edge.
    task automatic cycle(input bit v, input logic [127:0] d, input bit l, input bit h,
                         input bit re, input logic [IDX_W-1:0] ri);
        logic [127:0] exp_rd;
        bit           rd_known;
        bit           acc;
        bit           store;
        int           slot;
        in_valid = v; in_data = d; in_last = l; hold = h; rd_en = re; rd_idx = ri;
        #0.5;
        check("R1", "in_ready", 128'(in_ready), 128'(exp_ready(h)));
        acc      = v && exp_ready(h);
        store    = acc && (m_ptr < DEPTH);
        slot     = m_ptr;
        exp_rd   = m_mem[ri];
        rd_known = m_wr[ri];
        if (acc) begin
            m_count++;
            if (l) m_last = 1'b1;
        end
        if (store) begin
            m_mem[slot] = d;
            m_wr[slot]  = 1'b1;
            m_ptr++;
        end
        @(posedge clk);
        #1;
        check(acc ? "R4" : "R2", "beat_count", 128'(beat_count), 128'(m_count));
        check("R5", "last_flag", 128'(last_flag), 128'(m_last));
        check(store ? "R8" : "R7", "evt_valid", 128'(evt_valid), 128'(store));
        if (store) begin
            check("R3", "evt_slot", 128'(evt_slot), 128'(slot));
            check("R8", "evt_payload", 128'(evt_payload), low_half(d));
        end
        check("R6", "rd_valid", 128'(rd_valid), 128'(re));
        if (re && rd_known) check("R6", "rd_data", rd_data, exp_rd);
        @(negedge clk);
    endtask

    task automatic idle_read(input int idx);
        cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, IDX_W'(idx));
    endtask

    // R9: synchronous reset, then reset-state checks.
    task automatic do_reset();
        in_valid = 1'b0; in_data = '0; in_last = 1'b0; hold = 1'b0;
        rd_en = 1'b0; rd_idx = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_count = 0; m_last = 1'b0; m_ptr = 0;
        check("R9", "beat_count", 128'(beat_count), 128'd0);
        check("R9", "last_flag", 128'(last_flag), 128'd0);
        check("R9", "rd_valid", 128'(rd_valid), 128'd0);
        check("R9", "evt_valid", 128'(evt_valid), 128'd0);
    endtask

    task automatic random_run(input int n);
        for (int k = 0; k < n; k++) begin
            cycle($urandom_range(0, 3) != 0,
                  {$urandom, $urandom, $urandom, $urandom},
                  $urandom_range(0, 15) == 0,
                  $urandom_range(0, 2) == 0,
                  $urandom_range(0, 1) == 1,
                  IDX_W'($urandom_range(0, DEPTH - 1)));
        end
    endtask

    initial begin
        total = 0; bad = 0;
        for (int i = 0; i < DEPTH; i++) m_wr[i] = 1'b0;
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();

        // R3 / R2: two beats, then a long hold with valid held high, then resume.
        cycle(1'b1, pattern(0), 1'b0, 1'b0, 1'b0, '0);
        cycle(1'b1, pattern(1), 1'b0, 1'b0, 1'b0, '0);
        for (int k = 0; k < 6; k++) cycle(1'b1, pattern(2), 1'b0, 1'b1, 1'b0, '0);
        cycle(1'b1, pattern(2), 1'b0, 1'b0, 1'b0, '0);
        // R5 / R6: end-marked beat with a read of slot 0 on the same edge.
        cycle(1'b1, pattern(3), 1'b1, 1'b0, 1'b1, '0);
        for (int i = 0; i < 4; i++) idle_read(i);
        // R6: a read of the slot written on the same edge returns its old contents.
        cycle(1'b1, pattern(4), 1'b0, 1'b0, 1'b1, IDX_W'(4));
        idle_read(4);

        // Random traffic well past full (R7), then read every slot.
        random_run(250);
        for (int i = 0; i < DEPTH; i++) idle_read(i);

        // R9: reset mid-run; the next stored beat must go to slot 0.
        do_reset();
        cycle(1'b1, pattern(9), 1'b0, 1'b0, 1'b0, '0);
        idle_read(0);
        random_run(150);
        for (int i = 0; i < DEPTH; i++) idle_read(i);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule